// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a register-mapped general-purpose I/O port of up to 32 pins. Software reads the synchronised pin levels and sets a per-pin output value and a per-pin drive enable, so each pin can act as an input or as a driven output. A pad-side tri-state buffer is built outside the block from `pin_out` and `pin_oe`.

Every input passes through a two-flop synchroniser. The synchronised levels feed edge detection and the data read path. One interrupt line is produced. Its trigger mode is chosen at build time from rising edge, falling edge, both edges or level high, and software cannot change it. In the edge modes, detected events latch into a sticky capture register. Software clears that register by writing ones to it. A per-pin mask decides which pins can raise the interrupt.

The register bus is a single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high.

Top module: `pio_port`

## Requirements
- R1: Word registers are selected by `bus_addr[3:2]`: 0 is data, 1 is direction, 2 is interrupt mask, 3 is edge capture. An access with `bus_addr[1:0]` not zero is ignored. `bus_rdata` shows the selected register while `bus_rd` is high and reads zero while it is low.
- R2: A read of the data register returns the pin levels as sampled two clock edges after they change. A write to the data register sets `pin_out` from the next edge onward.
- R3: `pin_oe` equals the direction register: 1 drives the pin as an output and 0 leaves it as an input.
- R4: Register bits at positions NUM_PINS and above always read zero, and writes to those bits are discarded.
- R5: In rising mode, a 0-to-1 change of a synchronised pin sets its capture bit.
- R6: In falling mode, a 1-to-0 change sets the capture bit and a 0-to-1 change does not.
- R7: In both-edges mode, every change sets the capture bit.
- R8: In level-high mode, `irq` is the OR of (synchronised pin level AND mask). The capture register records rising edges in this mode but does not drive `irq`.
- R9: In the edge modes, `irq` is the OR of (capture AND mask). Captures are recorded while masked, so unmasking a pin whose capture bit is pending raises `irq` at once.
- R10: A write to the capture register clears the bits written as 1 and keeps the bits written as 0.
- R11: When a capture set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R12: Reset clears the output value, direction, mask and capture registers, so `pin_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output value for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted capture bit is visible within one read of register 3, and it also shows on `irq` as soon as the same pin is unmasked. A synchroniser or edge-detector fault changes which capture bits are set three edges after a pin change. A wrong level path shows on the data read two edges after the change. The case of a clear and a set landing in the same cycle is timed deliberately, because a design in which the clear wins loses that event silently: the capture read comes back zero.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BUS_W    = 32;
    localparam int MAX_PINS = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_CAP  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] out_v;
        logic [BUS_W-1:0] dir_v;
        logic [BUS_W-1:0] mask_v;
    } ctrl_t;

    // Ones in the low n bit positions of a bus word.
    function automatic logic [BUS_W-1:0] pin_mask(input int n);
        logic [63:0] t;
        t = (64'd1 << n) - 64'd1;
        return t[BUS_W-1:0];
    endfunction

endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge
    import pio_pkg::*;
#(
    parameter int    W    = 32,
    parameter trig_e TRIG = TRIG_BOTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] event_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;

    generate
        if (TRIG == TRIG_FALL) begin : g_fall
            assign event_o = prev_q & ~sync_q;
        end else if (TRIG == TRIG_BOTH) begin : g_both
            assign event_o = prev_q ^ sync_q;
        end else begin : g_rise
            assign event_o = sync_q & ~prev_q;
        end
    endgenerate

    // R2: the sampled level is the input as it stood two edges earlier
    a_r2_two_stage: assert property (@(posedge clk) disable iff (rst)
        $past(rst, 2) == 1'b0 |-> level_o == $past(pin_i, 2));

endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cap_o
);

    logic [W-1:0] cap_q;
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_we_i ? clr_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= (cap_q & ~clr_eff) | set_i;
        end
    end

    assign cap_o = cap_q;

    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        clr_we_i |=> (cap_o & $past(clr_i) & ~$past(set_i)) == '0);

    a_r10_bits_hold: assert property (@(posedge clk) disable iff (rst)
        !clr_we_i |=> (cap_o & $past(cap_o)) == $past(cap_o));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> (cap_o & $past(set_i)) == $past(set_i));

endmodule

// File: rtl/pio_ctrl_regs.sv
module pio_ctrl_regs
    import pio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  reg_sel_e         sel_i,
    input  logic [BUS_W-1:0] wdata_i,
    output ctrl_t            ctrl_o
);

    localparam logic [BUS_W-1:0] PIN_MASK = pin_mask(NUM_PINS);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we_i) begin
            case (sel_i)
                REG_DATA: ctrl_q.out_v  <= wdata_i & PIN_MASK;
                REG_DIR:  ctrl_q.dir_v  <= wdata_i & PIN_MASK;
                REG_MASK: ctrl_q.mask_v <= wdata_i & PIN_MASK;
                default:  ;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;

    a_r2_out_written: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i == REG_DATA) |=> ctrl_o.out_v == ($past(wdata_i) & PIN_MASK));

    a_r3_dir_written: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i == REG_DIR) |=> ctrl_o.dir_v == ($past(wdata_i) & PIN_MASK));

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int    NUM_PINS = 32,
    parameter trig_e TRIG     = TRIG_BOTH,
    parameter int    ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic                bus_rd,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam logic [BUS_W-1:0] PIN_MASK = pin_mask(NUM_PINS);

    logic                aligned;
    reg_sel_e            sel;
    logic                wr_ok;
    ctrl_t               ctrl;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] events;
    logic [NUM_PINS-1:0] cap;
    logic [BUS_W-1:0]    level_w;
    logic [BUS_W-1:0]    cap_w;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_ok   = bus_wr && aligned;

    pio_sync_edge #(.W(NUM_PINS), .TRIG(TRIG)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_in),
        .level_o (level),
        .event_o (events)
    );

    pio_capture #(.W(NUM_PINS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .set_i    (events),
        .clr_we_i (wr_ok && sel == REG_CAP),
        .clr_i    (bus_wdata[NUM_PINS-1:0]),
        .cap_o    (cap)
    );

    pio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_ok),
        .sel_i   (sel),
        .wdata_i (bus_wdata),
        .ctrl_o  (ctrl)
    );

    assign level_w = BUS_W'(level);
    assign cap_w   = BUS_W'(cap);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            case (sel)
                REG_DATA: bus_rdata = level_w;
                REG_DIR:  bus_rdata = ctrl.dir_v;
                REG_MASK: bus_rdata = ctrl.mask_v;
                default:  bus_rdata = cap_w;
            endcase
        end
    end

    assign pin_out = ctrl.out_v[NUM_PINS-1:0];
    assign pin_oe  = ctrl.dir_v[NUM_PINS-1:0];

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(level_w & ctrl.mask_v);
        end else begin : g_irq_edge
            assign irq = |(cap_w & ctrl.mask_v);
        end
    endgenerate

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mask_v == '0) |-> !irq);

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~PIN_MASK) == '0);

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;
    import pio_pkg::*;

    localparam int NI = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] pins = '0;

    logic [31:0] rd0, rd1, rd2, rd3;
    logic [31:0] po0, oe0;
    logic [19:0] po1, oe1;
    logic [7:0]  po2, oe2;
    logic [11:0] po3, oe3;
    logic        irq0, irq1, irq2, irq3;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;

    logic [31:0] m_out [NI];
    logic [31:0] m_dir [NI];
    logic [31:0] m_msk [NI];
    logic [31:0] m_cap [NI];

    always #5 clk = ~clk;

    pio_port #(.NUM_PINS(32), .TRIG(TRIG_RISE)) u_pio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rd0), .pin_in(pins), .pin_out(po0), .pin_oe(oe0), .irq(irq0));
    pio_port #(.NUM_PINS(20), .TRIG(TRIG_FALL)) u_pio_port_fall (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rd1), .pin_in(pins[19:0]), .pin_out(po1), .pin_oe(oe1), .irq(irq1));
    pio_port #(.NUM_PINS(8), .TRIG(TRIG_BOTH)) u_pio_port_both (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rd2), .pin_in(pins[7:0]), .pin_out(po2), .pin_oe(oe2), .irq(irq2));
    pio_port #(.NUM_PINS(12), .TRIG(TRIG_LEVEL)) u_pio_port_lvl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rd3), .pin_in(pins[11:0]), .pin_out(po3), .pin_oe(oe3), .irq(irq3));

    function automatic logic [31:0] pm(input int k);
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return 32'h000F_FFFF;
            2: return 32'h0000_00FF;
            default: return 32'h0000_0FFF;
        endcase
    endfunction

    // R5 rising (k=0), R6 falling (k=1), R7 both (k=2), R8 level records rising (k=3)
    function automatic logic [31:0] edges(input int k, input logic [31:0] o, input logic [31:0] n);
        case (k)
            1: return (o & ~n) & pm(k);
            2: return (o ^ n) & pm(k);
            default: return (n & ~o) & pm(k);
        endcase
    endfunction

    function automatic logic exp_irq(input int k);
        if (k == 3) return |(pins & m_msk[k] & pm(k));
        return |(m_cap[k] & m_msk[k]);
    endfunction

    function automatic logic [31:0] get_rd(input int k);
        case (k)
            0: return rd0;
            1: return 32'(rd1);
            2: return 32'(rd2);
            default: return 32'(rd3);
        endcase
    endfunction

    function automatic logic [31:0] get_po(input int k);
        case (k)
            0: return po0;
            1: return 32'(po1);
            2: return 32'(po2);
            default: return 32'(po3);
        endcase
    endfunction

    function automatic logic [31:0] get_oe(input int k);
        case (k)
            0: return oe0;
            1: return 32'(oe1);
            2: return 32'(oe2);
            default: return 32'(oe3);
        endcase
    endfunction

    function automatic logic get_irq(input int k);
        case (k)
            0: return irq0;
            1: return irq1;
            2: return irq2;
            default: return irq3;
        endcase
    endfunction

    task automatic chk(input string req, input int k, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d actual=%h expected=%h", req, k, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int k = 0; k < NI; k++) begin
            case (a[3:2])
                2'd0: m_out[k] = d & pm(k);
                2'd1: m_dir[k] = d & pm(k);
                2'd2: m_msk[k] = d & pm(k);
                default: m_cap[k] = m_cap[k] & ~d;
            endcase
        end
    endtask

    task automatic set_pins(input logic [31:0] nv);
        logic [31:0] ov;
        ov = pins;
        @(negedge clk);
        pins = nv;
        repeat (4) @(negedge clk);
        for (int k = 0; k < NI; k++) m_cap[k] = m_cap[k] | edges(k, ov, nv);
    endtask

    task automatic check_all();
        string ctag [NI];
        ctag[0] = "R5"; ctag[1] = "R6"; ctag[2] = "R7"; ctag[3] = "R8";
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            bus_addr = 4'(r * 4); bus_rd = 1'b1;
            #1;
            for (int k = 0; k < NI; k++) begin
                case (r)
                    0: chk("R2 data read", k, get_rd(k), pins & pm(k));
                    1: chk("R1 dir read", k, get_rd(k), m_dir[k]);
                    2: chk("R1 mask read", k, get_rd(k), m_msk[k]);
                    default: chk(ctag[k], k, get_rd(k), m_cap[k]);
                endcase
                chk("R4 upper bits", k, get_rd(k) & ~pm(k), 32'd0);
            end
            bus_rd = 1'b0;
            #1;
            for (int k = 0; k < NI; k++) chk("R1 idle read", k, get_rd(k), 32'd0);
        end
        for (int k = 0; k < NI; k++) begin
            chk("R2 pin_out", k, get_po(k), m_out[k]);
            chk("R3 pin_oe", k, get_oe(k), m_dir[k]);
            chk(k == 3 ? "R8 irq" : "R9 irq", k, 32'(get_irq(k)), 32'(exp_irq(k)));
        end
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            m_out[k] = '0; m_dir[k] = '0; m_msk[k] = '0; m_cap[k] = '0;
        end
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: state after reset
        check_all();

        // R4: writes above the pin count are discarded
        bus_write(4'h4, 32'hFFFF_FFFF);
        check_all();
        bus_write(4'h4, 32'h0);

        // R1: unaligned write has no effect on the mask register
        @(negedge clk);
        bus_addr = 4'h9; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check_all();

        // R9: masked capture, then unmask raises irq at once
        set_pins(32'h0000_0001);
        check_all();
        bus_write(4'h8, 32'h0000_0001);
        check_all();

        // R10: clear only bit 0, bit 1 kept
        set_pins(32'h0000_0003);
        bus_write(4'hC, 32'h0000_0001);
        check_all();
        bus_write(4'hC, 32'hFFFF_FFFF);
        set_pins(32'h0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        check_all();

        // R11: capture set and clearing write in the same cycle
        @(negedge clk);
        pins = 32'h0000_0010;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'hC; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int k = 0; k < NI; k++) m_cap[k] = edges(k, 32'h0, 32'h0000_0010);
        repeat (2) @(negedge clk);
        check_all();

        // random traffic
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 0) set_pins($urandom());
            else bus_write(4'($urandom_range(0, 3) * 4), $urandom());
            check_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule